// File: doc/BRIEF.md
# Configuration Page Option-Bits Decoder

This block sits between a flash byte-reader and a configuration streamer. After reset it walks a small option-bits sector in flash, one byte at a time, starting at a base address given on a strap input. The sector holds up to eight page descriptors and a one-byte image-format version. Once the whole sector has been read, the block drops `busy`. From then on, a page-select input picks one descriptor, and the block presents that page's full byte start and end addresses together with flags saying whether the page was programmed and whether the image version is one it understands.

Flash reads go through a request channel with valid/ready and a response channel with valid only. A request stays asserted with a stable address until the reader takes it, so back-pressure is applied by holding `rd_req_ready` low. Only one request is outstanding at a time. The block is always ready for a response while a request is outstanding. Each response carries exactly one byte, and a response that arrives while no request is outstanding is ignored. A start address is stored without its 13 low bits and is rebuilt on an 8 KB boundary. If the selected page is unprogrammed or the version is unknown, the block raises an error and drives both addresses to zero.

Top module: `cfg_page_decoder`

## Requirements
- R1: From reset, `busy` is 1 and every result output (`page_start`, `page_end`, `page_valid`, `version_ok`, `page_err`) is 0. `busy` falls on the clock edge that accepts the last sector byte, and it stays 0 until the next reset.
- R2: The sector is read in a fixed order. First come offsets 0x00 to 0x3F, then offset 0x80. Each byte is read at `base_addr` plus its offset, with one request outstanding at a time. A request that is not accepted keeps `rd_req_valid` high and `rd_req_addr` unchanged.
- R3: Page p (0 to 7) is described by bytes 8p to 8p+7, and both 32-bit words are little-endian. Bytes 8p+4 to 8p+7 hold the end byte address, which is output unchanged as `page_end`.
- R4: In the first word of an entry (bytes 8p to 8p+3), bits [31:13] are the start address. `page_start` is those bits with 13 zero bits appended, so bits [12:1] of that word never reach any output.
- R5: Bit 0 of the first word is an active-low page-valid flag: 0 means the page was programmed. `page_valid` is 1 exactly when that bit is 0.
- R6: The version byte sits at offset 0x80. `version_ok` is 1 only for the values 0x03 (plain image) and 0x04 (enhanced-compressed image).
- R7: `page_err` is 1 when the selected page is not valid or the version is not accepted. While `page_err` is 1, `page_start` and `page_end` are 0.
- R8: While `busy` is 1, `page_sel` has no effect on any output. Once `busy` is 0, the outputs reflect the value `page_sel` had at the previous clock edge, so they follow it with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | 32 | Byte address of the option-bits sector (static strap) |
| page_sel | input | 3 | Page to decode |
| rd_req_valid | output | 1 | Byte-read request valid |
| rd_req_ready | input | 1 | Reader accepts the request |
| rd_req_addr | output | 32 | Byte address requested |
| rd_rsp_valid | input | 1 | Returned byte is valid |
| rd_rsp_data | input | 8 | Returned byte |
| busy | output | 1 | Sector read still in progress |
| page_start | output | 32 | Byte start address of the selected page |
| page_end | output | 32 | Byte end address of the selected page |
| page_valid | output | 1 | Selected page is programmed |
| version_ok | output | 1 | Version byte is an accepted value |
| page_err | output | 1 | Selected page unusable |

## Verification
The in-line assertions check several rules on every cycle: a request that is not accepted is held stable, the block never issues a request while one is outstanding, `busy` never rises again once it has fallen, the start address is always 8 KB aligned, and the addresses are zero whenever `page_err` is set. Other behaviours are visible only in the bench's scenarios, where a behavioural model compares every output on every clock: the exact read order and addresses, the little-endian field decoding with junk in the dropped bits, the active-low valid flag, the accepted and rejected version values, and the one-cycle select latency with the select ignored while busy.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int ADDR_W      = 32;
  localparam int ENTRY_BYTES = 8;
  localparam int ALIGN_BITS  = 13;
  localparam int VER_OFFSET  = 'h80;
  localparam logic [7:0] VER_PLAIN  = 8'h03;
  localparam logic [7:0] VER_PACKED = 8'h04;

  typedef enum logic [1:0] {
    F_START,
    F_ISSUE,
    F_WAIT,
    F_DONE
  } fetch_state_t;

  typedef struct packed {
    logic [ADDR_W-ALIGN_BITS-1:0] start_hi;
    logic                         valid_n;
    logic [ADDR_W-1:0]            end_addr;
  } page_entry_t;
endpackage

// File: rtl/cpd_fetch.sv
module cpd_fetch
  import cpd_pkg::*;
#(
  parameter int PAGES = 8,
  parameter int IDX_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              busy
);
  localparam int TOTAL = PAGES * ENTRY_BYTES + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

  fetch_state_t      st;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] off;

  always_comb begin
    if (idx == LAST_IDX) off = ADDR_W'(VER_OFFSET);
    else                 off = ADDR_W'(idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= F_START;
      idx    <= '0;
      base_q <= '0;
    end else begin
      case (st)
        F_START: begin
          base_q <= base_addr;
          st     <= F_ISSUE;
        end
        F_ISSUE: if (req_ready) st <= F_WAIT;
        F_WAIT: if (rsp_valid) begin
          if (idx == LAST_IDX) st <= F_DONE;
          else begin
            idx <= idx + 1'b1;
            st  <= F_ISSUE;
          end
        end
        default: st <= F_DONE;
      endcase
    end
  end

  assign req_valid = (st == F_ISSUE);
  assign req_addr  = base_q + off;
  assign wr_en     = (st == F_WAIT) && rsp_valid;
  assign wr_idx    = idx;
  assign busy      = (st != F_DONE);

  // R2: an unaccepted request is held with a stable address
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R2: no new request while a byte is still owed
  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  // R1: busy never returns once the sector is read
  p_busy_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);
endmodule

// File: rtl/cpd_table.sv
module cpd_table
  import cpd_pkg::*;
#(
  parameter int PAGES = 8,
  parameter int IDX_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  output page_entry_t       entries [PAGES],
  output logic [7:0]        version
);
  localparam int TOTAL = PAGES * ENTRY_BYTES + 1;

  logic [7:0] bytes_q [TOTAL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) bytes_q[i] <= 8'hFF;
    end else if (wr_en) begin
      bytes_q[wr_idx] <= wr_data;
    end
  end

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    localparam int B = p * ENTRY_BYTES;
    assign entries[p] = '{
      start_hi: {bytes_q[B+3], bytes_q[B+2], bytes_q[B+1][7:5]},
      valid_n:  bytes_q[B][0],
      end_addr: {bytes_q[B+7], bytes_q[B+6], bytes_q[B+5], bytes_q[B+4]}
    };
  end

  assign version = bytes_q[TOTAL-1];
endmodule

// File: rtl/cpd_select.sv
module cpd_select
  import cpd_pkg::*;
#(
  parameter int PAGES = 8,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  page_entry_t       entries [PAGES],
  input  logic [7:0]        version,
  input  logic [SEL_W-1:0]  page_sel,
  output logic [ADDR_W-1:0] page_start,
  output logic [ADDR_W-1:0] page_end,
  output logic              page_valid,
  output logic              version_ok,
  output logic              page_err
);
  logic        in_range;
  page_entry_t ent;
  logic        pv, vo, ok;

  if (PAGES < (1 << SEL_W)) begin : g_range_chk
    assign in_range = (int'(page_sel) < PAGES);
  end else begin : g_range_full
    assign in_range = 1'b1;
  end

  always_comb begin
    ent = in_range ? entries[page_sel] : '1;
    pv  = in_range && !ent.valid_n;
    vo  = (version == VER_PLAIN) || (version == VER_PACKED);
    ok  = pv && vo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_start <= '0;
      page_end   <= '0;
      page_valid <= 1'b0;
      version_ok <= 1'b0;
      page_err   <= 1'b0;
    end else if (busy) begin
      page_start <= '0;
      page_end   <= '0;
      page_valid <= 1'b0;
      version_ok <= 1'b0;
      page_err   <= 1'b0;
    end else begin
      page_valid <= pv;
      version_ok <= vo;
      page_err   <= !ok;
      page_start <= ok ? {ent.start_hi, {ALIGN_BITS{1'b0}}} : '0;
      page_end   <= ok ? ent.end_addr : '0;
    end
  end

  // R4: rebuilt start address is always on an 8 KB boundary
  p_start_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    page_start[ALIGN_BITS-1:0] == '0);

  // R7: an errored result never carries addresses
  p_zero_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |-> (page_start == '0 && page_end == '0));

  // R1: while the sector is being read, the result stays quiet
  p_quiet_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!page_err && !page_valid && !version_ok));
endmodule

// File: rtl/cfg_page_decoder.sv
module cfg_page_decoder
  import cpd_pkg::*;
#(
  parameter int PAGES = 8,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       base_addr,
  input  logic [SEL_W-1:0]  page_sel,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [31:0]       rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [7:0]        rd_rsp_data,
  output logic              busy,
  output logic [31:0]       page_start,
  output logic [31:0]       page_end,
  output logic              page_valid,
  output logic              version_ok,
  output logic              page_err
);
  localparam int IDX_W = $clog2(PAGES * ENTRY_BYTES + 1);

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  page_entry_t      entries [PAGES];
  logic [7:0]       version;

  cpd_fetch #(.PAGES(PAGES), .IDX_W(IDX_W)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_addr(base_addr),
    .req_valid(rd_req_valid),
    .req_ready(rd_req_ready),
    .req_addr (rd_req_addr),
    .rsp_valid(rd_rsp_valid),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .busy     (busy)
  );

  cpd_table #(.PAGES(PAGES), .IDX_W(IDX_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(rd_rsp_data),
    .entries(entries),
    .version(version)
  );

  cpd_select #(.PAGES(PAGES), .SEL_W(SEL_W)) u_select (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .entries   (entries),
    .version   (version),
    .page_sel  (page_sel),
    .page_start(page_start),
    .page_end  (page_end),
    .page_valid(page_valid),
    .version_ok(version_ok),
    .page_err  (page_err)
  );
endmodule

// File: tb/cfg_page_decoder_tb_top.sv
module cfg_page_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_addr = '0;
  logic [2:0]  page_sel = '0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [7:0]  rd_rsp_data = '0;
  logic        busy;
  logic [31:0] page_start, page_end;
  logic        page_valid, version_ok, page_err;

  always #2 clk = ~clk;

  cfg_page_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .page_sel(page_sel),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .busy(busy), .page_start(page_start), .page_end(page_end),
    .page_valid(page_valid), .version_ok(version_ok), .page_err(page_err)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // flash image, indexed by offset from the sector base
  logic [7:0] fl [256];
  int         ready_mode = 0;
  int         cyc = 0;

  // responder state
  bit  pend = 0;
  int  pend_cnt = 0;
  int  pend_off = 0;
  int  hs_idx = 0;
  int  rsp_idx = 0;
  bit  rsp_last = 0;

  always @(negedge clk) begin
    cyc++;
    rd_rsp_valid <= 1'b0;
    rsp_last     <= 1'b0;
    if (!rst_n) begin
      pend = 0; hs_idx = 0; rsp_idx = 0;
      rd_req_ready <= 1'b0;
    end else begin
      if (pend) begin
        if (pend_cnt == 0) begin
          rd_rsp_valid <= 1'b1;
          rd_rsp_data  <= fl[pend_off];
          rsp_last     <= (rsp_idx == 64);
          rsp_idx++;
          pend = 0;
        end else pend_cnt--;
      end
      begin
        bit rdy;
        rdy = (ready_mode == 0) ? 1'b1 : ((cyc % 5) != 2 && (cyc % 7) != 3);
        rd_req_ready <= rdy;
        if (rd_req_valid && rdy) begin
          int exp_off;
          exp_off = (hs_idx < 64) ? hs_idx : 'h80;
          // R2: read order and address
          chk(hs_idx <= 64 && rd_req_addr == base_addr + 32'(exp_off), "R2", "read address",
              rd_req_addr, base_addr + 32'(exp_off));
          pend     = 1;
          pend_off = exp_off;
          pend_cnt = hs_idx % 3;
          hs_idx++;
        end
      end
    end
  end

  // behavioural reference model
  logic        e_busy;
  logic [31:0] e_start, e_end;
  logic        e_valid, e_vok, e_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_busy <= 1'b1; e_start <= '0; e_end <= '0;
      e_valid <= 1'b0; e_vok <= 1'b0; e_err <= 1'b0;
    end else begin
      if (rd_rsp_valid && rsp_last) e_busy <= 1'b0;
      if (e_busy) begin
        e_start <= '0; e_end <= '0; e_valid <= 1'b0; e_vok <= 1'b0; e_err <= 1'b0;
      end else begin
        int s;
        logic [31:0] w0, w1;
        bit v, vk;
        s  = int'(page_sel) * 8;
        w0 = {fl[s+3], fl[s+2], fl[s+1], fl[s]};
        w1 = {fl[s+7], fl[s+6], fl[s+5], fl[s+4]};
        v  = (w0[0] == 1'b0);
        vk = (fl['h80] == 8'h03) || (fl['h80] == 8'h04);
        e_valid <= v;
        e_vok   <= vk;
        e_err   <= !(v && vk);
        e_start <= (v && vk) ? (w0 & 32'hFFFF_E000) : 32'h0;
        e_end   <= (v && vk) ? w1 : 32'h0;
      end
    end
  end

  // per-clock comparison, tagged R8 because it follows page_sel timing
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == e_busy, "R1", "busy", 32'(busy), 32'(e_busy));
      chk(page_start == e_start, "R4 R8", "page_start", page_start, e_start);
      chk(page_end == e_end, "R3 R8", "page_end", page_end, e_end);
      chk(page_valid == e_valid, "R5", "page_valid", 32'(page_valid), 32'(e_valid));
      chk(version_ok == e_vok, "R6", "version_ok", 32'(version_ok), 32'(e_vok));
      chk(page_err == e_err, "R7", "page_err", 32'(page_err), 32'(e_err));
    end
  end

  task automatic fill(input logic [7:0] ver, input logic [7:0] vmask, input int seed);
    for (int i = 0; i < 256; i++) fl[i] = 8'hFF;
    for (int p = 0; p < 8; p++) begin
      logic [31:0] st, w0, en;
      st = 32'((p + 1 + seed) * 32'h0010_2000 + seed * 32'h0000_6000);
      st = st & 32'hFFFF_E000;
      // R4: junk in bits [12:1] must be dropped
      w0 = st | {19'h0, 12'h5A5 ^ 12'(p * 37 + seed), ~vmask[p]};
      en = st + 32'h000F_FFFF + 32'(p);
      for (int b = 0; b < 4; b++) begin
        fl[p*8 + b]     = w0[b*8 +: 8];
        fl[p*8 + 4 + b] = en[b*8 +: 8];
      end
    end
    fl['h80] = ver;
  endtask

  task automatic run_case(input logic [31:0] base, input logic [7:0] ver,
                          input logic [7:0] vmask, input int mode, input int seed);
    rst_n = 1'b0;
    base_addr = base;
    ready_mode = mode;
    fill(ver, vmask, seed);
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b1 && page_start == 0 && page_end == 0 && !page_err && !page_valid && !version_ok,
        "R1", "reset state", {27'h0, busy, page_valid, version_ok, page_err, 1'b0}, 32'h10);
    rst_n = 1'b1;
    // R8: select toggled during the read must have no effect
    while (busy) begin
      @(negedge clk);
      page_sel = page_sel + 3'd3;
    end
    for (int k = 0; k < 8; k++) begin
      page_sel = 3'(k);
      repeat (3) @(negedge clk);
    end
    for (int k = 0; k < 16; k++) begin
      page_sel = 3'((k * 5) % 8);
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    run_case(32'h0000_0000, 8'h03, 8'b1010_0110, 0, 0);
    run_case(32'h0100_0000, 8'h04, 8'hFF,        1, 3);
    run_case(32'h0020_0000, 8'h05, 8'hFF,        0, 5);
    run_case(32'h0300_0000, 8'hFF, 8'h00,        1, 1);
    run_case(32'h0004_2000, 8'h03, 8'b0101_1001, 1, 7);
    // R2: exactly 65 reads in the last case
    chk(hs_idx == 65, "R2", "read count", 32'(hs_idx), 32'd65);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule